// File: doc/BRIEF.md
# Position Counter with Unit-Timer Latch

This block keeps a 32-bit signed-agnostic position count that advances on count pulses (direction chosen by a direction line) and bounds it with a programmable maximum, wrapping at both ends. A free-running unit timer counts system-clock cycles up to a programmable period. Each time it expires it can copy the position into a timeout latch and, in relative mode, zero the counter. Reading the latch then gives the movement seen during the last period instead of an absolute position.

An index pulse copies the position into a separate index latch. Timer expiry and index events each set a sticky flag. Each flag drives the interrupt line only when its enable bit is set, and software clears flags by writing ones to a clear address. A single-cycle register port writes the configuration and reads the counter, the latches and the flags. Reads are combinational from the address.

Top module: `pos_tracker`

## Requirements
- R1: After a synchronous active-low reset, the position, the timer count, both latches, the flags, the interrupt enables and the control bits read as zero, the maximum (address 2) reads as all ones, and `irq` is low.
- R2: Writing the control register (address 0) with bit 4 set loads the position from the initial-value register (address 1) at that clock edge; bit 4 is not stored.
- R3: Count pulses change the position only while control bit 0 (enable) is set: with `cnt_dir`=1 the position rises by one per pulse, with `cnt_dir`=0 it falls by one.
- R4: Counting up from a position equal to or above the maximum gives zero; counting down from zero gives the maximum.
- R5: While control bit 1 (timer run) is set, the timer count (address 5) rises by one per clock; in a cycle where it equals the period (address 4) the timer expires and its next value is zero, so period P gives one expiry every P+1 cycles.
- R6: While control bit 1 is clear, the timer count holds, and a write to address 5 loads it; a write to address 5 while the timer runs is ignored.
- R7: On expiry with control bit 2 set, the timeout latch (address 6) takes the position held in the expiry cycle; with bit 2 clear the latch is unchanged.
- R8: With control bit 3 set, the position is zeroed at each expiry edge, and a count pulse in that cycle is lost; with bit 3 clear the position is not disturbed by expiry.
- R9: An `index_pulse` high in a cycle copies the position into the index latch (address 7) and sets flag bit 1.
- R10: Expiry sets flag bit 0 (flags at address 8); `irq` is high when any flag bit is set together with the same bit of the interrupt-enable register (address 9); writing address 10 clears exactly the flag bits written as one, except that a set event in the same cycle wins.
- R11: A write to the position register (address 3) loads the position directly and takes precedence over software initialisation, relative reset and counting in the same cycle.
- R12: Register map: 0 control (bits 3:0 readable), 1 initial value, 2 maximum, 3 position, 4 period, 5 timer count, 6 timeout latch, 7 index latch, 8 flags, 9 interrupt enable, 10 flag clear (reads zero); unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pulse | input | 1 | One count step in each cycle it is high |
| cnt_dir | input | 1 | Count direction, 1 = up, 0 = down |
| index_pulse | input | 1 | Index event, one per cycle it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The hardest situations to reach from the ports are same-cycle collisions. One is a count pulse arriving on the very edge where the timer expires in relative mode. The other is a flag being set in the cycle software clears it. The stimulus counts clock cycles from the control write that starts the timer, so that a stream of up pulses runs exactly into the expiry cycle. The expected latch and position values then follow from that count. For the flag collision, a clear write and an index pulse are driven in one cycle, and the flag is read back before any further event.

// File: rtl/pos_tracker_pkg.sv
// Shared constants and types for the position tracker.
// Assumes a 4-bit register address space.
package pos_tracker_pkg;

    localparam int ADDR_W  = 4;
    localparam int NUM_EVT = 2;   // flag 0: timer expiry, flag 1: index

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_INIT   = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_MAX    = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_POS    = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_TIMER  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_TLATCH = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_ILATCH = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_IRQEN  = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 4'd10;

    localparam int CTRL_W    = 4;
    localparam int INIT_BIT  = 4;   // self-clearing software-init request

    typedef struct packed {
        logic rel_mode;    // bit 3
        logic latch_on_to; // bit 2
        logic tmr_run;     // bit 1
        logic cnt_en;      // bit 0
    } ctrl_t;

endpackage

// File: rtl/pos_count_core.sv
// Position counter core.
// Next value priority: direct load, software init, relative reset, count step.
// Counting up from max (or above) wraps to zero; down from zero wraps to max.
// Assumes at most one count step per cycle.
module pos_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         pulse,
    input  logic         up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         init,
    input  logic [W-1:0] init_val,
    input  logic         rel_clr,
    input  logic [W-1:0] max_val,
    output logic [W-1:0] pos
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] pos_nxt;
    logic         step;

    assign step = cnt_en && pulse;

    // Select the next position by priority
    always_comb begin
        pos_nxt = pos;
        if (load)
            pos_nxt = load_val;
        else if (init)
            pos_nxt = init_val;
        else if (rel_clr)
            pos_nxt = '0;
        else if (step) begin
            if (up)
                pos_nxt = (pos >= max_val) ? '0 : pos + ONE;
            else
                pos_nxt = (pos == '0) ? max_val : pos - ONE;
        end
    end

    // Position register
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else
            pos <= pos_nxt;
    end

    a_r4_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !init && !rel_clr && step && up && pos >= max_val) |=> (pos == '0));

    a_r4_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !init && !rel_clr && step && !up && pos == '0) |=> (pos == $past(max_val)));

    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !init && !rel_clr && !step) |=> $stable(pos));

    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pos == $past(load_val)));

endmodule

// File: rtl/pos_unit_timer.sv
// Unit timer: counts clocks while running and expires when the count equals
// the period, restarting at zero. Holds while stopped; the count is writable
// only while stopped. Assumes the period is not changed below the count.
module pos_unit_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] period,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tcount,
    output logic         expire
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign expire = run && (tcount == period);

    // Timer count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcount <= '0;
        else if (run)
            tcount <= expire ? '0 : tcount + ONE;
        else if (wr)
            tcount <= wdata;
    end

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (tcount == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr) |=> $stable(tcount));

    a_r6_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (tcount == $past(tcount) + ONE));

endmodule

// File: rtl/pos_event_flags.sv
// Sticky event flags with write-one-to-clear and per-bit interrupt enable.
// A set event beats a clear of the same bit in the same cycle.
module pos_event_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    // Flag register: clear first, then set so that set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_eff) | set;
    end

    // Interrupt from enabled flags
    assign irq = |(flags & irq_en);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags & $past(clr_mask & ~set)) == '0));

endmodule

// File: rtl/pos_tracker.sv
// Position tracker top: register file, position counter, unit timer,
// timeout and index latches, and event flags with interrupt.
// Assumes one register access per cycle and combinational reads.
module pos_tracker
    import pos_tracker_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pulse,
    input  logic              cnt_dir,
    input  logic              index_pulse,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq
);

    ctrl_t               ctrl_q;
    logic [W-1:0]        init_q, max_q, period_q, tlatch_q, ilatch_q;
    logic [NUM_EVT-1:0]  irqen_q;
    logic [W-1:0]        pos, tcount;
    logic [NUM_EVT-1:0]  flags;
    logic                expire;
    logic                wr_ctrl, wr_pos, wr_timer, wr_clear, sw_init;

    assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_pos   = reg_wr && (reg_addr == ADR_POS);
    assign wr_timer = reg_wr && (reg_addr == ADR_TIMER);
    assign wr_clear = reg_wr && (reg_addr == ADR_CLEAR);
    assign sw_init  = wr_ctrl && reg_wdata[INIT_BIT];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            init_q   <= '0;
            max_q    <= '1;
            period_q <= '0;
            irqen_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL:   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADR_INIT:   init_q   <= reg_wdata;
                ADR_MAX:    max_q    <= reg_wdata;
                ADR_PERIOD: period_q <= reg_wdata;
                ADR_IRQEN:  irqen_q  <= reg_wdata[NUM_EVT-1:0];
                default: ;
            endcase
        end
    end

    pos_count_core #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (ctrl_q.cnt_en),
        .pulse    (cnt_pulse),
        .up       (cnt_dir),
        .load     (wr_pos),
        .load_val (reg_wdata),
        .init     (sw_init),
        .init_val (init_q),
        .rel_clr  (expire && ctrl_q.rel_mode),
        .max_val  (max_q),
        .pos      (pos)
    );

    pos_unit_timer #(.W(W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.tmr_run),
        .period (period_q),
        .wr     (wr_timer),
        .wdata  (reg_wdata),
        .tcount (tcount),
        .expire (expire)
    );

    // Timeout latch: capture position on expiry when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            tlatch_q <= '0;
        else if (expire && ctrl_q.latch_on_to)
            tlatch_q <= pos;
    end

    // Index latch: capture position on each index event
    always_ff @(posedge clk) begin
        if (!rst_n)
            ilatch_q <= '0;
        else if (index_pulse)
            ilatch_q <= pos;
    end

    pos_event_flags #(.N(NUM_EVT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      ({index_pulse, expire}),
        .clr_wr   (wr_clear),
        .clr_mask (reg_wdata[NUM_EVT-1:0]),
        .irq_en   (irqen_q),
        .flags    (flags),
        .irq      (irq)
    );

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            ADR_CTRL:   reg_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            ADR_INIT:   reg_rdata = init_q;
            ADR_MAX:    reg_rdata = max_q;
            ADR_POS:    reg_rdata = pos;
            ADR_PERIOD: reg_rdata = period_q;
            ADR_TIMER:  reg_rdata = tcount;
            ADR_TLATCH: reg_rdata = tlatch_q;
            ADR_ILATCH: reg_rdata = ilatch_q;
            ADR_FLAGS:  reg_rdata = {{(W-NUM_EVT){1'b0}}, flags};
            ADR_IRQEN:  reg_rdata = {{(W-NUM_EVT){1'b0}}, irqen_q};
            default:    reg_rdata = '0;
        endcase
    end

    a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q.latch_on_to) |=> (tlatch_q == $past(pos)));

    a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !(expire && ctrl_q.latch_on_to) |=> $stable(tlatch_q));

    a_r8_rel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_q.rel_mode && !wr_pos && !sw_init) |=> (pos == '0));

    a_r9_index: assert property (@(posedge clk) disable iff (!rst_n)
        index_pulse |=> (ilatch_q == $past(pos) && flags[1]));

endmodule

// File: tb/pos_tracker_tb_top.sv
// Scoreboard bench: driver tasks push expected reads into a queue,
// a monitor pops and compares them a quarter period after each falling edge.
module pos_tracker_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_pulse, cnt_dir, index_pulse, reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    pos_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_pulse   (cnt_pulse),
        .cnt_dir     (cnt_dir),
        .index_pulse (index_pulse),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    localparam logic [3:0] A_CTRL = 0, A_INIT = 1, A_MAX = 2, A_POS = 3,
                           A_PER = 4, A_TMR = 5, A_TLAT = 6, A_ILAT = 7,
                           A_FLG = 8, A_IEN = 9, A_CLR = 10;

    task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       input logic pl, input logic up, input logic ix);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        cnt_pulse = pl; cnt_dir = up; index_pulse = ix;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulses(input logic up, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0, 1'b1, up, 1'b0);
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        cyc(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0);
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 1'b0);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare queued expectations with the outputs mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = sb_q.pop_front();
                got = it.is_irq ? {31'd0, irq} : reg_rdata;
                n_vec++;
                if (got !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    // Stimulus
    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        cnt_pulse = 0; cnt_dir = 0; index_pulse = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: reset state and map
        chk_reg(A_POS,  32'd0,        "R1 position");
        chk_reg(A_MAX,  32'hFFFFFFFF, "R1 R12 maximum");
        chk_reg(A_FLG,  32'd0,        "R1 flags");
        chk_reg(A_TLAT, 32'd0,        "R1 timeout latch");
        chk_reg(A_ILAT, 32'd0,        "R1 index latch");
        chk_reg(4'd15,  32'd0,        "R12 unmapped");
        chk_irq(1'b0,                 "R1 irq");

        // R3: gating and direction
        pulses(1'b1, 3);
        chk_reg(A_POS, 32'd0, "R3 disabled pulses ignored");
        wr_reg(A_CTRL, 32'h1);
        pulses(1'b1, 3);
        pulses(1'b0, 1);
        chk_reg(A_POS, 32'd2, "R3 up three down one");

        // R4: wrap both ways
        pulses(1'b0, 3);
        chk_reg(A_POS, 32'hFFFFFFFF, "R4 down from zero to max");
        wr_reg(A_MAX, 32'd5);
        wr_reg(A_POS, 32'd5);
        pulses(1'b1, 1);
        chk_reg(A_POS, 32'd0, "R4 up from max to zero");
        pulses(1'b0, 1);
        chk_reg(A_POS, 32'd5, "R4 down from zero to small max");
        wr_reg(A_POS, 32'd9);
        pulses(1'b1, 1);
        chk_reg(A_POS, 32'd0, "R4 up from above max");
        wr_reg(A_MAX, 32'hFFFFFFFF);

        // R2: software init, bit 4 not stored
        wr_reg(A_INIT, 32'd100);
        wr_reg(A_CTRL, 32'h11);
        chk_reg(A_POS,  32'd100, "R2 init load");
        chk_reg(A_CTRL, 32'h1,   "R2 init bit not stored");

        // R11: direct load beats a count pulse
        cyc(1'b1, A_POS, 32'd42, 1'b1, 1'b1, 1'b0);
        chk_reg(A_POS, 32'd42, "R11 load over count");

        // R5: timer sequence with period 3
        wr_reg(A_PER, 32'd3);
        wr_reg(A_CTRL, 32'h3);
        chk_reg(A_TMR, 32'd0, "R5 count 0");
        chk_reg(A_TMR, 32'd1, "R5 count 1");
        chk_reg(A_TMR, 32'd2, "R5 count 2");
        chk_reg(A_TMR, 32'd3, "R5 count at period");
        chk_reg(A_FLG, 32'd1, "R10 expiry sets flag 0");
        chk_reg(A_TMR, 32'd1, "R5 restart after expiry");
        idle();
        wr_reg(A_CTRL, 32'h1);   // expires in this cycle, timer stops at 0
        chk_reg(A_TLAT, 32'd0, "R7 no latch with bit 2 clear");
        chk_reg(A_POS,  32'd42, "R8 absolute position untouched");

        // R6: hold and write rules
        chk_reg(A_TMR, 32'd0, "R6 hold while stopped");
        wr_reg(A_TMR, 32'd2);
        chk_reg(A_TMR, 32'd2, "R6 write while stopped");
        wr_reg(A_CTRL, 32'h3);
        wr_reg(A_TMR, 32'd0);
        chk_reg(A_TMR, 32'd3, "R6 write while running ignored");
        wr_reg(A_CTRL, 32'h1);
        wr_reg(A_TMR, 32'd0);

        // R7 / R8: relative mode with latch, pulse lost at expiry
        wr_reg(A_POS, 32'd10);
        wr_reg(A_PER, 32'd5);
        wr_reg(A_CTRL, 32'hF);
        pulses(1'b1, 6);
        chk_reg(A_TLAT, 32'd15, "R7 latch at expiry");
        chk_reg(A_POS,  32'd0,  "R8 relative reset, pulse lost");
        wr_reg(A_CTRL, 32'h1);
        wr_reg(A_TMR, 32'd0);

        // R8: absolute mode keeps position across expiry
        wr_reg(A_POS, 32'd20);
        wr_reg(A_PER, 32'd2);
        wr_reg(A_CTRL, 32'h7);
        idle(); idle(); idle();
        chk_reg(A_POS,  32'd20, "R8 absolute mode position");
        chk_reg(A_TLAT, 32'd20, "R7 latch in absolute mode");
        wr_reg(A_CTRL, 32'h1);

        // R10: interrupt masking and clear
        wr_reg(A_IEN, 32'd0);
        chk_irq(1'b0, "R10 masked flag");
        wr_reg(A_IEN, 32'd1);
        chk_irq(1'b1, "R10 enabled flag");
        wr_reg(A_CLR, 32'd1);
        chk_reg(A_FLG, 32'd0, "R10 clear flag 0");
        chk_irq(1'b0, "R10 irq drops after clear");

        // R9: index latch and flag
        wr_reg(A_POS, 32'd77);
        cyc(1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 1'b1);
        chk_reg(A_ILAT, 32'd77, "R9 index latch");
        chk_reg(A_FLG,  32'd2,  "R9 index flag");
        chk_irq(1'b0, "R10 index flag masked");
        wr_reg(A_IEN, 32'd2);
        chk_irq(1'b1, "R10 index flag enabled");

        // R10: clear only written bits, set beats clear
        wr_reg(A_CLR, 32'd1);
        chk_reg(A_FLG, 32'd2, "R10 clear leaves other bit");
        cyc(1'b1, A_CLR, 32'd2, 1'b0, 1'b0, 1'b1);
        chk_reg(A_FLG, 32'd2, "R10 set wins over clear");
        wr_reg(A_CLR, 32'd2);
        chk_reg(A_FLG, 32'd0, "R10 clear flag 1");

        idle(); idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule